// File: doc/BRIEF.md
# I2C converter control slave

This block is the two-wire control front end of a multi-channel data converter. It watches the serial clock and data lines and recognises its own 7-bit device address. It also recognises a shared broadcast address, so that every converter on the bus can be told to start at the same instant. A master may write a channel-select byte, or leave it out, and read back the most recent conversion result. The Stop condition that closes an accepted transaction is what launches the next conversion.

Between a conversion start and the converter's done indication, the slave refuses both addresses and leaves the data line alone. The serial lines are open-drain. The slave only ever pulls SDA low, through an output-enable, with the output value tied to zero. The analog converter, the input multiplexer and the oscillator sit outside the block. They are reached through a start pulse, a done input, a channel-select output and a result input.

Top module: `conv_i2c_slave`

## Requirements
- R1: After reset, sda_oe is 0, conv_start is 0 and chan_sel is 0. No conversion is in progress, and the held result is 0.
- R2: When no conversion is in progress, an address byte whose bits 7:1 equal DEV_ADDR is acknowledged for either value of bit 0 (1 = read, 0 = write). Any other address, apart from R3's, is answered with a NAK, and the slave then stays off SDA until the next Start.
- R3: The broadcast address 7'b1110111 with bit 0 = 0 is acknowledged. The master may then write one or more data bytes, each acknowledged, or none.
- R4: The broadcast address with bit 0 = 1 is answered with a NAK. The Stop that follows starts no conversion.
- R5: A Stop after an acknowledged write that carried data bytes loads chan_sel with bits CHAN_W-1:0 of the last data byte. The unread result is discarded, and chan_sel changes only in the cycle in which conv_start is high.
- R6: A Stop after an acknowledged address with no data byte, whether a write or a read, starts a conversion and leaves chan_sel unchanged.
- R7: On an acknowledged read, the result held from the latest conv_done pulse is sent most significant byte first and MSB first within each byte. Each master ACK requests another byte, and bytes beyond RESULT_BYTES read as 8'hFF. A master NAK ends the read.
- R8: A write, then a repeated Start, then a read returns the result of the previous conversion. The closing Stop starts exactly one new conversion and applies the written channel.
- R9: From a conv_start pulse until conv_done, both the device address and the broadcast address are answered with a NAK. A Stop in that period starts nothing.
- R10: conv_start is a one-cycle pulse, raised once per Stop that closes a transaction with an acknowledged address, and never otherwise.
- R11: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Serial data output value, constant 0 (open drain) |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| chan_sel | output | CHAN_W | Channel selection presented to the input multiplexer |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_done | input | 1 | One-cycle indication that a conversion finished and result is valid |
| result | input | 8*RESULT_BYTES | Conversion result, sampled when conv_done is high |

## Verification
The bench builds the block with DEV_ADDR = 7'h29, CHAN_W = 4, RESULT_BYTES = 3 and a two-stage synchroniser. With three result bytes, a fourth acknowledged read reaches the 8'hFF padding. A 4-bit channel field lets random write bytes show whether the upper bits are really dropped. The converter model takes 3000 cycles per conversion, which is longer than an addressed transaction. This lets the bench aim addresses and Stops squarely inside the busy window and again after conv_done.

// File: rtl/i2cs_pkg.sv
// Package: shared types for the converter control slave.
// Assumes nothing beyond a synthesizable enum encoding.
package i2cs_pkg;

    // Protocol engine phases
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, SDA released
        ST_RX,     // shifting in an address or data byte
        ST_ACK,    // holding SDA low for an acknowledge
        ST_TX,     // shifting out a result byte
        ST_TXACK   // waiting for the master's ACK or NAK
    } i2cs_state_e;

endpackage

// File: rtl/i2cs_line_sync.sv
// Module: i2cs_line_sync
// Brings SCL and SDA into the clk domain through STAGES flops and derives
// SCL edges plus Start/Stop events (SDA edge while SCL is high).
// Assumes clk is several times faster than SCL and STAGES >= 2.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0][1:0] chain;
    logic [1:0]             prev;

    // Shift the raw line pair through the synchroniser chain; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 2'b11;
        end else begin
            chain <= {chain[STAGES-2:0], {scl_i, sda_i}};
            prev  <= chain[STAGES-1];
        end
    end

    assign scl_s = chain[STAGES-1][1];
    assign sda_s = chain[STAGES-1][0];

    // Edge and bus-condition decode from current and previous sampled values
    always_comb begin
        scl_rise  = scl_s & ~prev[1];
        scl_fall  = ~scl_s & prev[1];
        start_det = scl_s & prev[1] & prev[0] & ~sda_s;
        stop_det  = scl_s & prev[1] & ~prev[0] & sda_s;
    end

endmodule

// File: rtl/i2cs_proto.sv
// Module: i2cs_proto
// Bit-level slave engine: address match (own and broadcast), write-byte
// capture, result read-out and Stop-driven trigger generation.
// Assumes synchronised lines and single-cycle event strobes from i2cs_line_sync.
module i2cs_proto
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h29,
    parameter logic [6:0] GLOBAL_ADDR  = 7'b1110111,
    parameter int         CHAN_W       = 4,
    parameter int         RESULT_BYTES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_s,
    input  logic                      sda_s,
    input  logic                      scl_rise,
    input  logic                      scl_fall,
    input  logic                      start_det,
    input  logic                      stop_det,
    input  logic                      busy,
    input  logic [8*RESULT_BYTES-1:0] rd_word,
    output logic                      sda_oe,
    output logic                      trig,
    output logic                      pend_valid,
    output logic [CHAN_W-1:0]         pend_chan
);
    localparam int IDX_W = $clog2(RESULT_BYTES + 1);

    i2cs_state_e      st;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic [2:0]       cnt;
    logic [IDX_W-1:0] idx;
    logic             full, is_addr, rd_mode, glob_q, accepted, mst_ack;
    logic [7:0]       first_byte, next_byte;

    // Result byte k counted from the most significant end; padding past the end
    function automatic logic [7:0] pick(input int k);
        if (k >= RESULT_BYTES) return 8'hFF;
        return rd_word[(RESULT_BYTES-1-k)*8 +: 8];
    endfunction

    // Bytes to load at the start of a read and after each master ACK
    always_comb begin
        first_byte = pick(0);
        next_byte  = pick(int'(idx) + 1);
    end

    // Protocol state machine; SDA changes only on SCL falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            sh         <= '0;
            tx         <= '1;
            cnt        <= '0;
            idx        <= '0;
            full       <= 1'b0;
            is_addr    <= 1'b0;
            rd_mode    <= 1'b0;
            glob_q     <= 1'b0;
            accepted   <= 1'b0;
            mst_ack    <= 1'b0;
            sda_oe     <= 1'b0;
            trig       <= 1'b0;
            pend_valid <= 1'b0;
            pend_chan  <= '0;
        end else begin
            trig <= 1'b0;
            if (trig) pend_valid <= 1'b0;
            if (stop_det) begin
                st       <= ST_IDLE;
                sda_oe   <= 1'b0;
                trig     <= accepted;
                accepted <= 1'b0;
            end else if (start_det) begin
                st      <= ST_RX;
                is_addr <= 1'b1;
                cnt     <= '0;
                full    <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (is_addr) begin
                                if (!busy && (sh[7:1] == DEV_ADDR ||
                                              (sh[7:1] == GLOBAL_ADDR && !sh[0]))) begin
                                    sda_oe   <= 1'b1;
                                    st       <= ST_ACK;
                                    rd_mode  <= sh[0];
                                    glob_q   <= (sh[7:1] != DEV_ADDR);
                                    accepted <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                sda_oe     <= 1'b1;
                                st         <= ST_ACK;
                                rd_mode    <= 1'b0;
                                pend_valid <= 1'b1;
                                pend_chan  <= sh[CHAN_W-1:0];
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                idx    <= '0;
                                tx     <= first_byte;
                                sda_oe <= ~first_byte[7];
                                st     <= ST_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                is_addr <= 1'b0;
                                st      <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TXACK;
                            end else begin
                                tx     <= {tx[6:0], 1'b1};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                if (int'(idx) < RESULT_BYTES) idx <= idx + 1'b1;
                                tx     <= next_byte;
                                sda_oe <= ~next_byte[7];
                                cnt    <= '0;
                                st     <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s)); // R11
    AST_NO_GLOBAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX) |-> !glob_q); // R4
    AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK && is_addr) |-> !busy); // R9
    AST_TRIG_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(accepted)); // R10

endmodule

// File: rtl/i2cs_phase.sv
// Module: i2cs_phase
// Tracks the sleep/converting/data-ready phases, issues the conversion
// start pulse, applies a pending channel and holds the finished result.
// Assumes trig is a single-cycle strobe and CHAN_W <= 8.
module i2cs_phase #(
    parameter int CHAN_W       = 4,
    parameter int RESULT_BYTES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig,
    input  logic                      pend_valid,
    input  logic [CHAN_W-1:0]         pend_chan,
    input  logic                      conv_done,
    input  logic [8*RESULT_BYTES-1:0] result,
    output logic                      conv_start,
    output logic                      busy,
    output logic [CHAN_W-1:0]         chan_sel,
    output logic [8*RESULT_BYTES-1:0] hold
);
    // Start pulse, busy window, channel update and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            busy       <= 1'b0;
            chan_sel   <= '0;
            hold       <= '0;
        end else begin
            conv_start <= trig;
            if (trig && pend_valid) chan_sel <= pend_chan;
            if (trig)           busy <= 1'b1;
            else if (conv_done) busy <= 1'b0;
            if (conv_done) hold <= result;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R10
    AST_CHAN_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_sel) |-> conv_start); // R5
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !trig) |=> !busy); // R9

endmodule

// File: rtl/conv_i2c_slave.sv
// Module: conv_i2c_slave (top)
// Two-wire slave controlling a converter: own and broadcast addressing,
// optional channel write, Stop-triggered conversion, result read-out.
// Assumes open-drain lines split into in/oe, clk much faster than SCL.
module conv_i2c_slave #(
    parameter logic [6:0] DEV_ADDR     = 7'h29,
    parameter logic [6:0] GLOBAL_ADDR  = 7'b1110111,
    parameter int         CHAN_W       = 4,
    parameter int         RESULT_BYTES = 3,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_o,
    output logic                      sda_oe,
    output logic [CHAN_W-1:0]         chan_sel,
    output logic                      conv_start,
    input  logic                      conv_done,
    input  logic [8*RESULT_BYTES-1:0] result
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, trig, pend_valid;
    logic [CHAN_W-1:0]         pend_chan;
    logic [8*RESULT_BYTES-1:0] hold;

    assign sda_o = 1'b0;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_proto #(
        .DEV_ADDR(DEV_ADDR), .GLOBAL_ADDR(GLOBAL_ADDR),
        .CHAN_W(CHAN_W), .RESULT_BYTES(RESULT_BYTES)
    ) u_proto (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .busy(busy), .rd_word(hold), .sda_oe(sda_oe), .trig(trig),
        .pend_valid(pend_valid), .pend_chan(pend_chan)
    );

    i2cs_phase #(.CHAN_W(CHAN_W), .RESULT_BYTES(RESULT_BYTES)) u_phase (
        .clk(clk), .rst_n(rst_n), .trig(trig), .pend_valid(pend_valid),
        .pend_chan(pend_chan), .conv_done(conv_done), .result(result),
        .conv_start(conv_start), .busy(busy), .chan_sel(chan_sel), .hold(hold)
    );

endmodule

// File: tb/sim_conv_i2c_slave.sv
// Bench: bus master tasks, converter model, directed and random transactions.
module sim_conv_i2c_slave;
    localparam logic [6:0] DEV  = 7'h29;
    localparam logic [6:0] GLOB = 7'b1110111;
    localparam int CW = 4;
    localparam int RB = 3;
    localparam int HP = 12;
    localparam int CONV = 3000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_o, sda_oe, conv_start, conv_done = 1'b0;
    logic [CW-1:0] chan_sel;
    logic [8*RB-1:0] result = '0;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0, starts = 0, conv_left = 0, r11_bad = 0;
    bit busy_m = 1'b0;
    logic [8*RB-1:0] hold_m = '0;
    logic [CW-1:0] exp_chan = '0;

    always #4 clk = ~clk;

    conv_i2c_slave #(.DEV_ADDR(DEV), .CHAN_W(CW), .RESULT_BYTES(RB)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .chan_sel(chan_sel),
        .conv_start(conv_start), .conv_done(conv_done), .result(result));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ack(input logic [6:0] a, input bit rw, input bit busy);
        return !busy && (a == DEV || (a == GLOB && !rw));
    endfunction

    function automatic logic [7:0] exp_byte(input logic [8*RB-1:0] w, input int k);
        if (k >= RB) return 8'hFF;
        return w[(RB-1-k)*8 +: 8];
    endfunction

    // Count start pulses and watch for SDA pulls beginning while SCL is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (conv_start) starts++;
        if (sda_oe && !oe_prev && scl_m) r11_bad++;
        oe_prev = sda_oe;
    end

    // Converter model: fixed latency, new random result at each done
    always @(negedge clk) begin
        if (conv_start) begin
            busy_m = 1'b1;
            for (int i = CONV; i > 0; i--) begin conv_left = i; @(negedge clk); end
            result = 24'($urandom);
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            hold_m = result;
            busy_m = 1'b0;
            conv_left = 0;
        end
    end

    task automatic wt(input int n); repeat (n) @(negedge clk); endtask

    task automatic i2c_start;
        sda_m = 1'b1; scl_m = 1'b1; wt(HP); sda_m = 1'b0; wt(HP); scl_m = 1'b0;
    endtask
    task automatic i2c_rstart;
        wt(HP/2); sda_m = 1'b1; wt(HP/2); scl_m = 1'b1; wt(HP); sda_m = 1'b0; wt(HP); scl_m = 1'b0;
    endtask
    task automatic i2c_stop;
        wt(HP/2); sda_m = 1'b0; wt(HP/2); scl_m = 1'b1; wt(HP); sda_m = 1'b1; wt(HP);
    endtask
    task automatic send_bit(input bit b);
        wt(HP/2); sda_m = b; wt(HP/2); scl_m = 1'b1; wt(HP); scl_m = 1'b0;
    endtask
    task automatic recv_bit(output bit b);
        wt(HP/2); sda_m = 1'b1; wt(HP/2); scl_m = 1'b1; wt(HP/2); b = sda_line; wt(HP/2); scl_m = 1'b0;
    endtask
    task automatic write_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask
    task automatic read_byte(input bit ackm, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(!ackm);
    endtask

    task automatic wait_ready;
        while (busy_m) wt(1);
        wt(4);
    endtask

    // Stop, then check pulse count and channel against the model
    task automatic stop_and_check(input int pulses, input string req);
        int s0;
        s0 = starts;
        i2c_stop();
        wt(4);
        check(starts - s0 == pulses, req, "start pulses after Stop", starts - s0, pulses);
        check(chan_sel == exp_chan, req, "chan_sel after Stop", chan_sel, exp_chan);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        void'($urandom(32'd2024));
        wt(5);
        rst_n = 1'b1;
        wt(2);
        // R1 reset state
        check(sda_oe == 1'b0, "R1", "sda_oe", sda_oe, 0);
        check(conv_start == 1'b0, "R1", "conv_start", conv_start, 0);
        check(chan_sel == '0, "R1", "chan_sel", chan_sel, 0);

        // R2/R5: own write with channel byte
        i2c_start(); write_byte({DEV, 1'b0}, ack);
        check(ack, "R2", "own write address ack", ack, 1);
        write_byte(8'hF5, ack);
        check(ack, "R5", "data byte ack", ack, 1);
        exp_chan = 4'h5;
        stop_and_check(1, "R5");

        // R9: both addresses refused during the conversion, Stop does nothing
        i2c_start(); write_byte({DEV, 1'b0}, ack);
        check(!ack, "R9", "own address while busy", ack, 0);
        i2c_rstart(); write_byte({GLOB, 1'b0}, ack);
        check(!ack, "R9", "global address while busy", ack, 0);
        stop_and_check(0, "R9");
        wait_ready();

        // R7: read all bytes plus one padding byte
        i2c_start(); write_byte({DEV, 1'b1}, ack);
        check(ack, "R2", "own read address ack", ack, 1);
        for (int k = 0; k <= RB; k++) begin
            read_byte(k < RB, d);
            check(d == exp_byte(hold_m, k), "R7", "read byte", d, exp_byte(hold_m, k));
        end
        stop_and_check(1, "R6");
        wait_ready();

        // R3/R6: broadcast write without data
        i2c_start(); write_byte({GLOB, 1'b0}, ack);
        check(ack, "R3", "global write ack", ack, 1);
        stop_and_check(1, "R6");
        wait_ready();

        // R3/R5: broadcast write with data
        i2c_start(); write_byte({GLOB, 1'b0}, ack);
        check(ack, "R3", "global write ack", ack, 1);
        write_byte(8'h3A, ack);
        check(ack, "R3", "global data ack", ack, 1);
        exp_chan = 4'hA;
        stop_and_check(1, "R5");
        wait_ready();

        // R4: broadcast read refused
        i2c_start(); write_byte({GLOB, 1'b1}, ack);
        check(!ack, "R4", "global read nak", ack, 0);
        stop_and_check(0, "R4");

        // R2/R10: foreign address
        i2c_start(); write_byte({7'h2A, 1'b0}, ack);
        check(!ack, "R2", "foreign address nak", ack, 0);
        check(sda_oe == 1'b0, "R2", "SDA released after nak", sda_oe, 0);
        stop_and_check(0, "R10");

        // R8: write, repeated Start, read previous result
        i2c_start(); write_byte({DEV, 1'b0}, ack);
        write_byte(8'h03, ack);
        i2c_rstart(); write_byte({DEV, 1'b1}, ack);
        check(ack, "R8", "read after repeated start ack", ack, 1);
        for (int k = 0; k < RB; k++) begin
            read_byte(k < RB - 1, d);
            check(d == exp_byte(hold_m, k), "R8", "previous result byte", d, exp_byte(hold_m, k));
        end
        exp_chan = 4'h3;
        stop_and_check(1, "R8");

        // Random mix of transactions, sometimes inside the busy window
        for (int it = 0; it < 24; it++) begin
            int kind;
            bit rw, nb, busy_now, exp_a;
            logic [6:0] a;
            logic [7:0] wb;
            kind = $urandom_range(0, 6);
            wb = 8'($urandom);
            if ($urandom_range(0, 3) != 0 || (busy_m && conv_left < 600)) wait_ready();
            busy_now = busy_m;
            case (kind)
                0: begin a = DEV;  rw = 1'b0; nb = 1'b1; end
                1: begin a = DEV;  rw = 1'b0; nb = 1'b0; end
                2: begin a = GLOB; rw = 1'b0; nb = 1'b1; end
                3: begin a = GLOB; rw = 1'b0; nb = 1'b0; end
                4: begin a = DEV;  rw = 1'b1; nb = 1'b0; end
                5: begin a = GLOB; rw = 1'b1; nb = 1'b0; end
                default: begin
                    a = 7'($urandom);
                    if (a == DEV || a == GLOB) a = 7'h11;
                    rw = 1'($urandom); nb = 1'b0;
                end
            endcase
            exp_a = exp_ack(a, rw, busy_now);
            i2c_start(); write_byte({a, rw}, ack);
            check(ack == exp_a, "R2", "random address ack", ack, exp_a);
            if (ack && !rw && nb) begin
                write_byte(wb, ack);
                check(ack, "R5", "random data ack", ack, 1);
                exp_chan = wb[CW-1:0];
            end
            if (exp_a && rw) begin
                for (int k = 0; k < RB; k++) begin
                    read_byte(k < RB - 1, d);
                    check(d == exp_byte(hold_m, k), "R7", "random read byte", d, exp_byte(hold_m, k));
                end
            end
            stop_and_check(exp_a ? 1 : 0, "R10");
        end
        wait_ready();
        check(r11_bad == 0, "R11", "SDA pulls begun with SCL high", r11_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule